// File: doc/BRIEF.md
# Calendar Update Engine with BCD/Binary Time Bytes

This block keeps the time-of-day, the calendar and the time-of-day alarm for a real-time clock. Software sees ten byte registers through a simple synchronous write port and a combinational read port. Once per second an update strobe arrives from an external divider. The engine then advances its internal count by one second, carrying into minutes, hours, day of week, date, month and year. It applies month lengths, leap years and optional daylight-saving jumps. It compares the new time against the three alarm bytes and copies the result back into the software-visible bytes.

The internal count is held as plain binary, in 24-hour form. Formatting into binary or BCD, and into 12-hour or 24-hour form, happens only when the count is published to the visible bytes. Parsing in the other direction happens only when software releases the hold input after loading a new time. While the hold input is high, the visible time bytes are frozen so that software can rewrite them safely. Releasing the hold input loads those bytes into the count.

Top module: `calTop`

## Requirements
- R1: Byte addresses are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week (1..7, Sunday = 1), 7 date, 8 month, 9 year (0..99). After reset the time bytes read 00:00:00, day 1, date 1, month 1, year 0. Alarm bytes read back exactly what was written.
- R2: Bit 7 of the seconds byte always reads 0, even after 0xFF is written to it.
- R3: A tick sampled at rising edge k raises `updateDone` for exactly one cycle, after edge k+2. Ticks sampled during the two following edges are ignored.
- R4: With `binMode`=1 every time byte is plain binary. With `binMode`=0 each byte is two BCD digits. Seconds carry into minutes, minutes into hours and hours into the next day in both formats.
- R5: With `hr24`=0 the hours byte holds 1..12 in bits 6:0 and PM in bit 7. 11:59:59 AM is followed by 12:00:00 PM, 12:59:59 PM by 1:00:00 PM, and 11:59:59 PM by 12:00:00 AM of the next day. With `hr24`=1, hours run 0..23.
- R6: Month lengths are 30 for months 4, 6, 9 and 11, 31 for the other months, and 28 for February. February has 29 when the year is a multiple of 4, and year 0 counts as a multiple of 4.
- R7: Day of week wraps from 7 to 1 at midnight. The year wraps from 99 to 0 after December 31.
- R8: While `setHold`=1, updates still pulse `updateDone`, but the visible time bytes keep their values unless software writes them.
- R9: When `setHold` falls, the visible time bytes are loaded into the count. The next update advances from that time.
- R10: An alarm byte whose bits 7:6 are both 1 matches any value. `alarmHit` pulses in the same cycle as `updateDone` when all three alarm bytes match the new time.
- R11: With `dstEn`=1, on a Sunday in April with date 1..7, 1:59:59 is followed by 3:00:00. With `dstEn`=0, or on another Sunday, 2:00:00 follows.
- R12: With `dstEn`=1, on a Sunday in October with date 25..31, 1:59:59 is followed by 1:00:00 once. A second pass on the same day goes on to 2:00:00. The once-only flag clears at the next midnight.
- R13: A write to a time byte while `setHold`=0 reads back at once. The next update overwrites it with the formatted count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second update strobe |
| setHold | input | 1 | Freeze visible time bytes; falling edge loads them into the count |
| binMode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour hours byte, 0 = 12-hour with PM bit |
| dstEn | input | 1 | Enables the daylight-saving jumps |
| wrEn | input | 1 | Byte write enable |
| addr | input | 4 | Byte address for read and write |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed byte (0 above address 9) |
| alarmHit | output | 1 | One-cycle pulse when the alarm matches |
| updateDone | output | 1 | One-cycle pulse when an update completes |

## Verification
A wrong carry, month length or mode conversion stays hidden inside the binary count until the next publish. The bench therefore loads a time just before a boundary, issues one tick and reads all seven time bytes three edges later, so a bad rollover shows as a wrong byte within one update. A lost or stuck daylight-saving flag only shows on a second pass through the same hour, so that case is loaded twice. A bad alarm decode shows as a missing or extra `alarmHit` in the cycle of `updateDone`.

// File: rtl/calPkg.sv
package calPkg;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned NUM_BYTES = 10;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_SECAL = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_MINAL = 4'd3;
  localparam logic [ADDR_W-1:0] A_HR    = 4'd4;
  localparam logic [ADDR_W-1:0] A_HRAL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_DOW   = 4'd6;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'd7;
  localparam logic [ADDR_W-1:0] A_MON   = 4'd8;
  localparam logic [ADDR_W-1:0] A_YR    = 4'd9;

  typedef struct packed {
    logic doInc;
    logic doCmp;
    logic doLoad;
  } calStrobe_t;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] dow;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } calCount_t;

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [7:0] hrEnc(input logic [4:0] h, input logic mode24, input logic bin);
    logic [4:0] h12;
    logic [7:0] b;
    if (mode24) return enc({2'b00, h}, bin);
    if (h == 5'd0)       h12 = 5'd12;
    else if (h > 5'd12)  h12 = h - 5'd12;
    else                 h12 = h;
    b = enc({2'b00, h12}, bin);
    return {(h >= 5'd12), b[6:0]};
  endfunction

  function automatic logic [4:0] hrDec(input logic [7:0] b, input logic mode24, input logic bin);
    logic [4:0] h12;
    if (mode24) return 5'(dec(b, bin));
    h12 = 5'(dec({1'b0, b[6:0]}, bin));
    if (h12 == 5'd12) return b[7] ? 5'd12 : 5'd0;
    return b[7] ? h12 + 5'd12 : h12;
  endfunction

  function automatic logic [4:0] daysIn(input logic [3:0] m, input logic [6:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       setHold,
  output calStrobe_t strobe
);
  typedef enum logic [1:0] { ST_IDLE, ST_INC, ST_CMP } calState_e;

  calState_e state;
  logic      setPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      setPrev <= 1'b0;
    end else begin
      setPrev <= setHold;
      case (state)
        ST_IDLE: if (tick) state <= ST_INC;
        ST_INC:  state <= ST_CMP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.doLoad = setPrev & ~setHold;
    strobe.doInc  = (state == ST_INC);
    strobe.doCmp  = (state == ST_CMP);
  end
endmodule

// File: rtl/calData.sv
module calData
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  calStrobe_t        strobe,
  input  logic              setHold,
  input  logic              binMode,
  input  logic              hr24,
  input  logic              dstEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmHit,
  output logic              updateDone
);
  calCount_t         cnt, nxt, ld;
  logic              fallDone, nxtFall;
  logic              springJump, fallJump, lastSec;
  logic              secOk, minOk, hrOk;
  logic [DATA_W-1:0] userB [NUM_BYTES];
  logic [DATA_W-1:0] pubB  [NUM_BYTES];

  // next-second arithmetic on the canonical binary 24-hour count
  always_comb begin
    nxt     = cnt;
    nxtFall = fallDone;
    lastSec = (cnt.hr == 5'd1) && (cnt.min == 6'd59) && (cnt.sec == 6'd59) && (cnt.dow == 3'd1) && dstEn;
    springJump = lastSec && (cnt.mon == 4'd4)  && (cnt.date <= 5'd7);
    fallJump   = lastSec && (cnt.mon == 4'd10) && (cnt.date >= 5'd25) && !fallDone;
    if (cnt.sec < 6'd59) begin
      nxt.sec = cnt.sec + 6'd1;
    end else begin
      nxt.sec = 6'd0;
      if (cnt.min < 6'd59) begin
        nxt.min = cnt.min + 6'd1;
      end else begin
        nxt.min = 6'd0;
        if (springJump) begin
          nxt.hr = 5'd3;
        end else if (fallJump) begin
          nxt.hr  = 5'd1;
          nxtFall = 1'b1;
        end else if (cnt.hr < 5'd23) begin
          nxt.hr = cnt.hr + 5'd1;
        end else begin
          nxt.hr  = 5'd0;
          nxtFall = 1'b0;
          nxt.dow = (cnt.dow >= 3'd7) ? 3'd1 : cnt.dow + 3'd1;
          if (cnt.date < daysIn(cnt.mon, cnt.yr)) begin
            nxt.date = cnt.date + 5'd1;
          end else begin
            nxt.date = 5'd1;
            if (cnt.mon < 4'd12) begin
              nxt.mon = cnt.mon + 4'd1;
            end else begin
              nxt.mon = 4'd1;
              nxt.yr  = (cnt.yr >= 7'd99) ? 7'd0 : cnt.yr + 7'd1;
            end
          end
        end
      end
    end
  end

  // parse visible bytes into the count
  always_comb begin
    ld.sec  = 6'(dec(userB[A_SEC],  binMode));
    ld.min  = 6'(dec(userB[A_MIN],  binMode));
    ld.hr   = hrDec(userB[A_HR], hr24, binMode);
    ld.dow  = 3'(dec(userB[A_DOW],  binMode));
    ld.date = 5'(dec(userB[A_DATE], binMode));
    ld.mon  = 4'(dec(userB[A_MON],  binMode));
    ld.yr   = dec(userB[A_YR], binMode);
  end

  // format the count for publishing
  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) pubB[i] = '0;
    pubB[A_SEC]  = enc({1'b0, cnt.sec}, binMode);
    pubB[A_MIN]  = enc({1'b0, cnt.min}, binMode);
    pubB[A_HR]   = hrEnc(cnt.hr, hr24, binMode);
    pubB[A_DOW]  = enc({4'd0, cnt.dow}, binMode);
    pubB[A_DATE] = enc({2'd0, cnt.date}, binMode);
    pubB[A_MON]  = enc({3'd0, cnt.mon}, binMode);
    pubB[A_YR]   = enc(cnt.yr, binMode);
  end

  // alarm compare with don't-care codes
  always_comb begin
    secOk = (userB[A_SECAL][7:6] == 2'b11) || (dec(userB[A_SECAL], binMode) == {1'b0, cnt.sec});
    minOk = (userB[A_MINAL][7:6] == 2'b11) || (dec(userB[A_MINAL], binMode) == {1'b0, cnt.min});
    hrOk  = (userB[A_HRAL][7:6]  == 2'b11) || (hrDec(userB[A_HRAL], hr24, binMode) == cnt.hr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '{sec: 6'd0, min: 6'd0, hr: 5'd0, dow: 3'd1, date: 5'd1, mon: 4'd1, yr: 7'd0};
      fallDone   <= 1'b0;
      alarmHit   <= 1'b0;
      updateDone <= 1'b0;
    end else begin
      alarmHit   <= strobe.doCmp && secOk && minOk && hrOk;
      updateDone <= strobe.doCmp;
      if (strobe.doLoad) begin
        cnt <= ld;
      end else if (strobe.doInc) begin
        cnt      <= nxt;
        fallDone <= nxtFall;
      end
    end
  end

  // visible byte file
  for (genvar i = 0; i < NUM_BYTES; i++) begin : gByte
    localparam bit          IS_TIME = (i >= 6) || ((i % 2) == 0);
    localparam bit          IS_SEC  = (i == 0);
    localparam logic [7:0]  RST_VAL = (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (wrEn && (addr == ADDR_W'(i))) begin
        q <= IS_SEC ? {1'b0, wrData[6:0]} : wrData;
      end else if (IS_TIME && strobe.doCmp && !setHold) begin
        q <= pubB[i];
      end
    end
    assign userB[i] = q;
  end

  assign rdData = (addr < ADDR_W'(NUM_BYTES)) ? userB[addr] : '0;
endmodule

// File: rtl/calTop.sv
module calTop
  import calPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              setHold,
  input  logic              binMode,
  input  logic              hr24,
  input  logic              dstEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmHit,
  output logic              updateDone
);
  calStrobe_t strobe;

  calCtrl uCtrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .setHold(setHold), .strobe(strobe)
  );

  calData uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .setHold(setHold),
    .binMode(binMode), .hr24(hr24), .dstEn(dstEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .alarmHit(alarmHit), .updateDone(updateDone)
  );
endmodule

// File: rtl/calChk.sv
module calChk
  import calPkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              setHold,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              alarmHit,
  input logic              updateDone
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    updateDone |=> !updateDone); // R3
  AST_DONE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    updateDone |-> $past(tick, 3)); // R3
  AST_ALARM_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    alarmHit |-> updateDone); // R10
  AST_SEC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SEC) |-> !rdData[7]); // R2
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(setHold) && !$past(wrEn) && $stable(addr)) |-> $stable(rdData)); // R8
endmodule

bind calTop calChk uChk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .setHold(setHold), .wrEn(wrEn),
  .addr(addr), .rdData(rdData), .alarmHit(alarmHit), .updateDone(updateDone)
);

// File: tb/tb_calTop.sv
module tb_calTop;
  import calPkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, setHold = 1'b0, binMode = 1'b0, hr24 = 1'b1, dstEn = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       alarmHit, updateDone;
  int         nChecks = 0, nErr = 0;

  always #4 clk = ~clk;

  calTop dut (.*);

  // {bin, h24, dst, start sec,min,hr,dow,date,mon,yr, expected after one tick}
  localparam logic [114:0] VECS [13] = '{
    {3'b010, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R4 R7 BCD new year
    {3'b110, 56'h3B_3B_17_03_1C_02_17, 56'h00_00_00_04_01_03_17}, // R6 Feb 28 non-leap
    {3'b110, 56'h3B_3B_17_03_1C_02_18, 56'h00_00_00_04_1D_02_18}, // R6 Feb 29 leap
    {3'b010, 56'h59_59_23_05_29_02_00, 56'h00_00_00_06_01_03_00}, // R6 year 00 leap
    {3'b000, 56'h59_59_11_02_10_05_21, 56'h00_00_92_02_10_05_21}, // R5 AM to 12 PM
    {3'b000, 56'h59_59_92_02_10_05_21, 56'h00_00_81_02_10_05_21}, // R5 12 PM to 1 PM
    {3'b100, 56'h3B_3B_8B_02_1E_04_15, 56'h00_00_0C_03_01_05_15}, // R5 R6 11 PM to 12 AM, Apr 30
    {3'b010, 56'h09_00_05_02_15_06_21, 56'h10_00_05_02_15_06_21}, // R4 BCD digit carry
    {3'b011, 56'h59_59_01_01_03_04_21, 56'h00_00_03_01_03_04_21}, // R11 spring jump
    {3'b010, 56'h59_59_01_01_03_04_21, 56'h00_00_02_01_03_04_21}, // R11 jump off
    {3'b011, 56'h59_59_01_01_08_04_21, 56'h00_00_02_01_08_04_21}, // R11 second Sunday
    {3'b001, 56'h59_59_01_01_07_04_21, 56'h00_00_03_01_07_04_21}, // R11 12-hour spring
    {3'b110, 56'h3B_0A_05_04_0F_07_1E, 56'h00_0B_05_04_0F_07_1E}  // R4 binary minute carry
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdData;
  endtask

  task automatic readTime(output logic [55:0] t);
    logic [7:0] b0, b2, b4, b6, b7, b8, b9;
    rd(4'd0, b0); rd(4'd2, b2); rd(4'd4, b4); rd(4'd6, b6);
    rd(4'd7, b7); rd(4'd8, b8); rd(4'd9, b9);
    t = {b0, b2, b4, b6, b7, b8, b9};
  endtask

  task automatic loadTime(input logic [55:0] t, input logic bm, input logic h, input logic d);
    @(negedge clk); binMode = bm; hr24 = h; dstEn = d; setHold = 1'b1;
    wr(4'd0, t[55:48]); wr(4'd2, t[47:40]); wr(4'd4, t[39:32]); wr(4'd6, t[31:24]);
    wr(4'd7, t[23:16]); wr(4'd8, t[15:8]);  wr(4'd9, t[7:0]);
    @(negedge clk); setHold = 1'b0;
    @(negedge clk);
  endtask

  task automatic doTick(output logic done, output logic alm);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    @(negedge clk); done = updateDone; alm = alarmHit;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin : main
    logic [55:0] t;
    logic [7:0]  b;
    logic        done, alm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    readTime(t);
    chk("R1 reset time bytes", {8'h0, t}, {8'h0, 56'h00_00_00_01_01_01_00});
    chk("R3 no done after reset", {63'h0, updateDone}, 64'h0);

    // vector table
    for (int i = 0; i < 13; i++) begin
      loadTime(VECS[i][111:56], VECS[i][114], VECS[i][113], VECS[i][112]);
      doTick(done, alm);
      chk($sformatf("R3 vector %0d done", i), {63'h0, done}, 64'h1);
      readTime(t);
      chk($sformatf("R4 R5 R6 R7 R11 vector %0d", i), {8'h0, t}, {8'h0, VECS[i][55:0]});
    end

    // R12 fall back once
    loadTime(56'h59_59_01_01_25_10_21, 1'b0, 1'b1, 1'b1);
    doTick(done, alm);
    readTime(t);
    chk("R12 first fall back", {8'h0, t}, {8'h0, 56'h00_00_01_01_25_10_21});
    loadTime(56'h59_59_01_01_25_10_21, 1'b0, 1'b1, 1'b1);
    doTick(done, alm);
    readTime(t);
    chk("R12 second pass no repeat", {8'h0, t}, {8'h0, 56'h00_00_02_01_25_10_21});

    // R10 alarm with don't-care codes
    loadTime(56'h04_00_00_01_01_01_00, 1'b0, 1'b1, 1'b0);
    wr(4'd1, 8'h05); wr(4'd3, 8'hC0); wr(4'd5, 8'hFF);
    doTick(done, alm);
    chk("R10 dont-care alarm hit", {62'h0, done, alm}, 64'h3);
    doTick(done, alm);
    chk("R10 mismatch no alarm", {62'h0, done, alm}, 64'h2);
    wr(4'd1, 8'h07); wr(4'd3, 8'h00); wr(4'd5, 8'h00);
    doTick(done, alm);
    chk("R10 exact alarm hit", {63'h0, alm}, 64'h1);
    rd(4'd1, b);
    chk("R1 alarm byte readback", {56'h0, b}, 64'h07);
    rd(4'd5, b);
    chk("R1 hours alarm readback", {56'h0, b}, 64'h00);

    // R13 write with hold low, then overwritten
    wr(4'd0, 8'h30);
    rd(4'd0, b);
    chk("R13 direct write readback", {56'h0, b}, 64'h30);
    doTick(done, alm);
    rd(4'd0, b);
    chk("R13 overwritten by update", {56'h0, b}, 64'h08);

    // R8 freeze
    @(negedge clk); setHold = 1'b1;
    doTick(done, alm);
    rd(4'd0, b);
    chk("R8 frozen seconds", {56'h0, b}, 64'h08);
    chk("R8 done while frozen", {63'h0, done}, 64'h1);

    // R2 top bit of seconds
    wr(4'd0, 8'hFF);
    rd(4'd0, b);
    chk("R2 seconds bit7 zero", {56'h0, b}, 64'h7F);

    // R9 load on hold release
    wr(4'd0, 8'h45);
    @(negedge clk); setHold = 1'b0;
    @(negedge clk);
    doTick(done, alm);
    rd(4'd0, b);
    chk("R9 load then advance", {56'h0, b}, 64'h46);

    // R3 tick held over busy cycles gives one update
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk("R3 done after long tick", {63'h0, updateDone}, 64'h1);
    @(negedge clk);
    chk("R3 done single cycle", {63'h0, updateDone}, 64'h0);
    rd(4'd0, b);
    chk("R3 single advance", {56'h0, b}, 64'h47);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule